// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block keeps the vector configuration of a vector-thread processor: how many integer and floating-point registers each lane uses, the largest vector length those demands allow (`cur_vlmax`), and the vector length currently granted (`cur_vl`). Both lengths are exported to the units that sequence lanes. Two operations change the state. A configure operation takes a 12-bit immediate with the two per-lane register counts and a requested length. A set-length operation takes only a requested length.

A configure operation divides the physical register pool of each class, less one register, by that class's per-lane demand less one. It keeps the tighter of the two quotients and limits the result to the lane count. It then grants the smaller of the new maximum and the requested length. One serial divider is shared by the two register classes and produces one quotient bit per cycle, so a configure operation takes about twenty cycles and signals completion with a `done` pulse. A set-length operation needs no division and completes one cycle after it is accepted. The granted length is returned on `grant_vl` in the `done` cycle so that it can be written to a scalar destination register.

Top module: `vlen_cfg_unit`

## Requirements
- R1: A cycle with synchronous reset high forces `cur_vl` = 0, `cur_vlmax` = 8, `busy` = 0 and `done` = 0, clears both per-lane counts and abandons any operation in flight.
- R2: In a configure immediate, bits [5:0] are the per-lane integer register count and bits [11:6] the per-lane FP register count. When both counts are zero, the new `cur_vlmax` is 8.
- R3: When exactly one count n is nonzero and n ≥ 2, the new `cur_vlmax` is min(32, floor(255 / (n − 1))).
- R4: When both counts are nonzero, the new `cur_vlmax` is the smaller of the two per-class limits, each computed as in R3 or R5.
- R5: A count of exactly 1 places no limit on its class, so only the lane cap of 32 applies to that class.
- R6: The granted length is min(`cur_vlmax`, requested length), where the request is a signed 32-bit value and a negative request grants 0. A configure operation computes this from the newly derived `cur_vlmax`.
- R7: A set-length operation accepted while idle raises `done` in the next cycle with `cur_vl` and `grant_vl` updated, and leaves `cur_vlmax` unchanged.
- R8: A configure operation raises `busy` from the cycle after acceptance and raises `done` no later than 22 cycles after acceptance, with default parameters. In the `done` cycle `busy` is 0.
- R9: Whenever `done` is 1, `grant_vl` equals `cur_vl`.
- R10: While `busy` is 1, both request inputs are ignored. When both are asserted in the same idle cycle, the configure operation is taken and the set-length operation is dropped.
- R11: `cur_vl` never exceeds `cur_vlmax`, and `cur_vlmax` always lies between 1 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Request a configure operation |
| cfg_imm | input | 12 | Per-lane counts: FP in [11:6], integer in [5:0] |
| setvl_valid | input | 1 | Request a set-length operation |
| req_len | input | 32 | Requested vector length, signed |
| busy | output | 1 | Configure operation in progress |
| done | output | 1 | Operation complete, `grant_vl` valid |
| grant_vl | output | 6 | Granted vector length for the destination register |
| cur_vl | output | 6 | Current vector length |
| cur_vlmax | output | 6 | Current maximum vector length |

## Verification
A wrong quotient bit, a wrong class index or a bad cap appears on `cur_vlmax` and `grant_vl` in the `done` cycle of the configure operation that produced it, so every table vector checks both values there, with counts chosen to reach each branch: zero, one, a single class, both classes and the cap. A stuck state machine appears as a `done` that never arrives or arrives late, which the per-operation latency measurement catches. A wrong acceptance rule appears as a set-length result that shows up while the block is busy, or as a dropped configure operation; the priority and busy-window tests look at `done`, `busy` and `cur_vl` within one or two cycles of the offending request.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  // Register classes: 0 = integer, 1 = floating point
  localparam int NCLASS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_FIN
  } cfg_state_e;
endpackage

// File: rtl/vcfg_seq_div.sv
// Restoring unsigned divider, one quotient bit per clock.
module vcfg_seq_div #(
  parameter int NUM_W = 8,
  parameter int DEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic              running;
  logic [STEP_W-1:0] steps;
  logic [DEN_W:0]    rem;
  logic [DEN_W-1:0]  den_q;
  logic [DEN_W:0]    trial;
  logic [DEN_W:0]    den_ext;

  always_comb begin
    trial   = {rem[DEN_W-1:0], quot[NUM_W-1]};
    den_ext = {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      steps   <= '0;
      rem     <= '0;
      den_q   <= '0;
      quot    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running <= 1'b1;
        steps   <= STEP_W'(NUM_W);
        rem     <= '0;
        den_q   <= denom;
        quot    <= numer;
      end else if (running) begin
        if (trial >= den_ext) begin
          rem  <= trial - den_ext;
          quot <= {quot[NUM_W-2:0], 1'b1};
        end else begin
          rem  <= trial;
          quot <= {quot[NUM_W-2:0], 1'b0};
        end
        steps <= steps - 1'b1;
        if (steps == STEP_W'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  // A count of 1 must never reach the divider (R5)
  p_div_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> (denom != '0));

  // The controller waits for completion before starting again
  p_div_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    start |-> !running);

  // The remainder stays below the divisor while running
  p_div_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
    running |-> (rem < den_ext));
endmodule

// File: rtl/vcfg_limit.sv
// Folds the per-class quotients into one maximum vector length.
module vcfg_limit #(
  parameter int NCLASS    = 2,
  parameter int CNT_W     = 6,
  parameter int NUM_W     = 8,
  parameter int LANES     = 32,
  parameter int VL_W      = 6,
  parameter int DEF_VLMAX = 8
) (
  input  logic [CNT_W-1:0] cnts  [NCLASS],
  input  logic [NUM_W-1:0] quots [NCLASS],
  output logic [VL_W-1:0]  vlmax
);
  logic [NCLASS-1:0] used;
  logic [VL_W-1:0]   cap [NCLASS];

  for (genvar k = 0; k < NCLASS; k++) begin : g_cls
    always_comb begin
      used[k] = (cnts[k] != '0);
      if (cnts[k] == CNT_W'(1))
        cap[k] = VL_W'(LANES);
      else if (int'(quots[k]) > LANES)
        cap[k] = VL_W'(LANES);
      else
        cap[k] = VL_W'(quots[k]);
    end
  end

  always_comb begin
    logic [VL_W-1:0] best;
    best = VL_W'(LANES);
    for (int k = 0; k < NCLASS; k++) begin
      if (used[k] && (cap[k] < best))
        best = cap[k];
    end
    vlmax = (used == '0) ? VL_W'(DEF_VLMAX) : best;
  end
endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit #(
  parameter int LANES     = 32,
  parameter int XPR_POOL  = 256,
  parameter int FPR_POOL  = 256,
  parameter int CNT_W     = 6,
  parameter int LEN_W     = 32,
  parameter int DEF_VLMAX = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_valid,
  input  logic [CNT_W*vcfg_pkg::NCLASS-1:0]      cfg_imm,
  input  logic                                   setvl_valid,
  input  logic [LEN_W-1:0]                       req_len,
  output logic                                   busy,
  output logic                                   done,
  output logic [$clog2(LANES+1)-1:0]             grant_vl,
  output logic [$clog2(LANES+1)-1:0]             cur_vl,
  output logic [$clog2(LANES+1)-1:0]             cur_vlmax
);
  import vcfg_pkg::*;

  localparam int VL_W    = $clog2(LANES + 1);
  localparam int MAXPOOL = (XPR_POOL > FPR_POOL) ? XPR_POOL : FPR_POOL;
  localparam int NUM_W   = $clog2(MAXPOOL);
  localparam int CLS_W   = (NCLASS > 1) ? $clog2(NCLASS) : 1;
  localparam int LAT_MAX = NCLASS * (NUM_W + 2) + 2;
  localparam int LAT_W   = $clog2(LAT_MAX + 1) + 1;

  cfg_state_e       st;
  logic [CLS_W-1:0] cls;
  logic [CNT_W-1:0] cnt_q  [NCLASS];
  logic [NUM_W-1:0] quot_q [NCLASS];
  logic [LEN_W-1:0] req_q;
  logic [VL_W-1:0]  vl_r;
  logic [VL_W-1:0]  vlmax_r;
  logic [VL_W-1:0]  grant_r;
  logic             done_r;

  logic             div_start;
  logic             div_done;
  logic [NUM_W-1:0] div_quot;
  logic [NUM_W-1:0] div_numer;
  logic [CNT_W-1:0] div_denom;
  logic             need_div;
  logic             last_cls;
  logic [VL_W-1:0]  lim;

  function automatic logic [VL_W-1:0] grant_len(input logic [VL_W-1:0] mx,
                                                input logic [LEN_W-1:0] rq);
    if (rq[LEN_W-1])
      return '0;
    else if (rq > LEN_W'(mx))
      return mx;
    else
      return rq[VL_W-1:0];
  endfunction

  always_comb begin
    need_div  = (cnt_q[cls] > CNT_W'(1));
    last_cls  = (cls == CLS_W'(NCLASS - 1));
    div_start = (st == ST_LOAD) && need_div;
    div_denom = cnt_q[cls] - CNT_W'(1);
    div_numer = (cls == '0) ? NUM_W'(XPR_POOL - 1) : NUM_W'(FPR_POOL - 1);
  end

  vcfg_seq_div #(
    .NUM_W (NUM_W),
    .DEN_W (CNT_W)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .numer (div_numer),
    .denom (div_denom),
    .done  (div_done),
    .quot  (div_quot)
  );

  vcfg_limit #(
    .NCLASS    (NCLASS),
    .CNT_W     (CNT_W),
    .NUM_W     (NUM_W),
    .LANES     (LANES),
    .VL_W      (VL_W),
    .DEF_VLMAX (DEF_VLMAX)
  ) u_lim (
    .cnts  (cnt_q),
    .quots (quot_q),
    .vlmax (lim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cls     <= '0;
      req_q   <= '0;
      vl_r    <= '0;
      vlmax_r <= VL_W'(DEF_VLMAX);
      grant_r <= '0;
      done_r  <= 1'b0;
      for (int k = 0; k < NCLASS; k++) begin
        cnt_q[k]  <= '0;
        quot_q[k] <= '0;
      end
    end else begin
      done_r <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cfg_valid) begin
            for (int k = 0; k < NCLASS; k++)
              cnt_q[k] <= cfg_imm[k*CNT_W +: CNT_W];
            req_q <= req_len;
            cls   <= '0;
            st    <= ST_LOAD;
          end else if (setvl_valid) begin
            vl_r    <= grant_len(vlmax_r, req_len);
            grant_r <= grant_len(vlmax_r, req_len);
            done_r  <= 1'b1;
          end
        end
        ST_LOAD: begin
          if (need_div)
            st <= ST_WAIT;
          else if (last_cls)
            st <= ST_FIN;
          else
            cls <= cls + 1'b1;
        end
        ST_WAIT: begin
          if (div_done) begin
            quot_q[cls] <= div_quot;
            if (last_cls) begin
              st <= ST_FIN;
            end else begin
              cls <= cls + 1'b1;
              st  <= ST_LOAD;
            end
          end
        end
        ST_FIN: begin
          vlmax_r <= lim;
          vl_r    <= grant_len(lim, req_q);
          grant_r <= grant_len(lim, req_q);
          done_r  <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = done_r;
  assign grant_vl  = grant_r;
  assign cur_vl    = vl_r;
  assign cur_vlmax = vlmax_r;

  // Cycles spent busy in the current operation, for the latency bound
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) lat_cnt <= '0;
    else              lat_cnt <= lat_cnt + 1'b1;
  end

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_vl == '0 && cur_vlmax == VL_W'(DEF_VLMAX) && !busy && !done));

  p_vl_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cur_vl <= cur_vlmax);

  p_vlmax_range_r11: assert property (@(posedge clk) disable iff (rst)
    (cur_vlmax <= VL_W'(LANES)) && (cur_vlmax != '0));

  p_setvl_timing_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && setvl_valid && !cfg_valid) |=> (done && $stable(cur_vlmax)));

  p_grant_match_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (grant_vl == cur_vl));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && st != ST_FIN) |=> ($stable(cur_vl) && $stable(cur_vlmax) && !done));

  p_cfg_priority_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && cfg_valid) |=> (busy && !done));

  p_cfg_latency_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lat_cnt < LAT_W'(LAT_MAX)));
endmodule

// File: tb/sim_vlen_cfg_unit.sv
module sim_vlen_cfg_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_valid = 1'b0;
  logic [11:0] cfg_imm = '0;
  logic        setvl_valid = 1'b0;
  logic [31:0] req_len = '0;
  logic        busy, done;
  logic [5:0]  grant_vl, cur_vl, cur_vlmax;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  vlen_cfg_unit u0 (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_imm(cfg_imm),
    .setvl_valid(setvl_valid), .req_len(req_len), .busy(busy), .done(done),
    .grant_vl(grant_vl), .cur_vl(cur_vl), .cur_vlmax(cur_vlmax)
  );

  // {fp count, int count, request, expected vlmax, expected vl}
  localparam int NVEC = 13;
  localparam logic [59:0] VEC [NVEC] = '{
    {6'd0,  6'd0,  32'd100,        8'd8,  8'd8},
    {6'd0,  6'd2,  32'd100,        8'd32, 8'd32},
    {6'd0,  6'd9,  32'd100,        8'd31, 8'd31},
    {6'd0,  6'd10, 32'd5,          8'd28, 8'd5},
    {6'd17, 6'd0,  32'd50,         8'd15, 8'd15},
    {6'd20, 6'd40, 32'd1000,       8'd6,  8'd6},
    {6'd40, 6'd20, 32'd3,          8'd6,  8'd3},
    {6'd63, 6'd63, 32'd100,        8'd4,  8'd4},
    {6'd0,  6'd1,  32'd40,         8'd32, 8'd32},
    {6'd63, 6'd1,  32'd40,         8'd4,  8'd4},
    {6'd1,  6'd0,  32'd0,          8'd32, 8'd0},
    {6'd5,  6'd33, 32'hFFFF_FFFB,  8'd7,  8'd0},
    {6'd1,  6'd1,  32'd31,         8'd32, 8'd31}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, then count rising edges until done is seen
  task automatic run_op(input logic c, input logic s, input logic [11:0] imm,
                        input logic [31:0] rq, output int lat);
    @(negedge clk);
    cfg_valid = c; setvl_valid = s; cfg_imm = imm; req_len = rq;
    @(negedge clk);
    cfg_valid = 1'b0; setvl_valid = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    string tg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cur_vl", cur_vl, 0);
    chk("R1", "cur_vlmax", cur_vlmax, 8);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [5:0] fc, xc;
      int evm, evl, esv;
      fc = VEC[i][59:54]; xc = VEC[i][53:48];
      evm = VEC[i][15:8]; evl = VEC[i][7:0];
      if (fc == 0 && xc == 0)      tg = "R2";
      else if (fc == 1 || xc == 1) tg = "R5";
      else if (fc != 0 && xc != 0) tg = "R4";
      else                         tg = "R3";
      run_op(1'b1, 1'b0, {fc, xc}, VEC[i][47:16], lat);
      chk(tg, "vlmax", cur_vlmax, evm);
      chk("R6", "grant_vl", grant_vl, evl);
      chk("R6", "cur_vl", cur_vl, evl);
      chk("R8", "latency_ok", (lat <= 22) ? 1 : 0, 1);
      chk("R8", "busy_at_done", busy, 0);
      // R7 set-length after configure keeps vlmax
      esv = (evm < 17) ? evm : 17;
      run_op(1'b0, 1'b1, 12'h000, 32'd17, lat);
      chk("R7", "setvl_latency", lat, 1);
      chk("R7", "setvl_vl", cur_vl, esv);
      chk("R7", "setvl_vlmax", cur_vlmax, evm);
    end

    // R6 negative request via set-length, then exact and oversized
    run_op(1'b1, 1'b0, {6'd0, 6'd10}, 32'd9, lat);     // vlmax 28
    run_op(1'b0, 1'b1, 12'h000, 32'h8000_0000, lat);
    chk("R6", "neg_req", grant_vl, 0);
    run_op(1'b0, 1'b1, 12'h000, 32'd28, lat);
    chk("R6", "req_eq_vlmax", grant_vl, 28);
    run_op(1'b0, 1'b1, 12'h000, 32'h7FFF_FFFF, lat);
    chk("R6", "req_huge", grant_vl, 28);

    // R7 back-to-back set-length in consecutive cycles
    @(negedge clk);
    setvl_valid = 1'b1; req_len = 32'd3;
    @(negedge clk);
    chk("R7", "b2b_first", cur_vl, 3);
    req_len = 32'd11;
    @(negedge clk);
    setvl_valid = 1'b0;
    chk("R7", "b2b_second", cur_vl, 11);
    chk("R9", "b2b_done", done, 1);

    // R10 set-length while busy is ignored
    @(negedge clk);
    cfg_valid = 1'b1; cfg_imm = {6'd0, 6'd10}; req_len = 32'd5;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R8", "busy_after_accept", busy, 1);
    repeat (3) @(negedge clk);
    setvl_valid = 1'b1; req_len = 32'd2;
    @(negedge clk);
    setvl_valid = 1'b0;
    chk("R10", "no_done_while_busy", done, 0);
    chk("R10", "vl_held_while_busy", cur_vl, 11);
    lat = 0;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    chk("R10", "vl_after_busy", cur_vl, 5);
    @(negedge clk);
    chk("R10", "no_late_setvl", cur_vl, 5);

    // R10 configure wins over simultaneous set-length
    @(negedge clk);
    cfg_valid = 1'b1; setvl_valid = 1'b1; cfg_imm = 12'h000; req_len = 32'd3;
    @(negedge clk);
    cfg_valid = 1'b0; setvl_valid = 1'b0;
    chk("R10", "prio_busy", busy, 1);
    chk("R10", "prio_no_done", done, 0);
    lat = 0;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    chk("R10", "prio_vlmax", cur_vlmax, 8);
    chk("R10", "prio_vl", cur_vl, 3);

    // R1 reset during a configure operation
    run_op(1'b1, 1'b0, {6'd0, 6'd9}, 32'd20, lat);     // vl 20, vlmax 31
    @(negedge clk);
    cfg_valid = 1'b1; cfg_imm = {6'd63, 6'd63}; req_len = 32'd1;
    @(negedge clk);
    cfg_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "mid_op_vl", cur_vl, 0);
    chk("R1", "mid_op_vlmax", cur_vlmax, 8);
    chk("R1", "mid_op_busy", busy, 0);
    repeat (25) @(negedge clk);
    chk("R1", "no_stale_done_vlmax", cur_vlmax, 8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule